// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block joins two 18-bit ports, A and B, with two independent one-way paths: one from A to B and one from B to A. Each path has a storage element that is both a level-sensitive latch and an edge-triggered register. Run-time controls pick how it behaves: it can pass data straight through, hold the last value, capture on a rising edge of the path's own clock, or capture on that edge only while a clock enable is asserted. Each path also has an active-low output enable that decides whether its destination port drives or floats.

The block runs on one system clock, `clk`. The per-path clocks, latch enables and clock enables are sampled on that clock. A path clock edge is found by comparing the sampled value with the value held from the previous cycle. Every port is split into an input bus, an output bus and a drive flag. The surrounding bench or pad ring uses the drive flag to decide whether the port is driven or left floating. The block does not stop both directions from driving at once. Each drive flag is exported on its own, so contention can be seen outside the block.

Top module: `xcvr_bidir`

## Requirements
- R1: Both ports and both paths are `W` bits wide, with `W` = 18 by default.
- R2: While a path's latch enable is 1, its output takes the input value sampled at each `clk` rising edge. The new value is visible one `clk` cycle later. The latch enable takes priority over the path clock and the clock enable.
- R3: While the latch enable is 0 and the sampled path clock does not change from 0 to 1, the path output keeps its value.
- R4: While the latch enable is 0 and the clock enable (active low, 0 = enabled) is 0, a 0-to-1 change of the sampled path clock stores the input sampled in that same `clk` cycle. The stored value appears on the output one `clk` cycle later.
- R5: When the clock enable is 1, a rising path clock edge stores nothing. Lowering the clock enable afterwards, while the path clock stays high, also stores nothing.
- R6: A path's drive flag (`b_oe` for A-to-B, `a_oe` for B-to-A) is 1 exactly when `rst_n` is 1 and that path's active-low output enable is 0. The flag follows the enable in the same cycle. The data output keeps the stored value whether or not the path drives.
- R7: When the latch enable falls from 1 to 0 while the path clock is steady, the path holds the last value it passed through.
- R8: The two paths work independently, and both drive flags may be 1 at the same time.
- R9: While `rst_n` is 0 (synchronous reset, active low), both drive flags are 0. At the next `clk` edge both stored values become zero. The edge history takes the current path clock level, so a clock that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | W | Value present on port A |
| a_out | output | W | Value the B-to-A path presents to port A |
| a_oe | output | 1 | 1 when the B-to-A path drives port A |
| b_in | input | W | Value present on port B |
| b_out | output | W | Value the A-to-B path presents to port B |
| b_oe | output | 1 | 1 when the A-to-B path drives port B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_pclk | input | 1 | A-to-B path clock |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_pclk | input | 1 | B-to-A path clock |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |

## Verification
The A-to-B path is driven through a sequence that tests the modes in turn:
- A path clock edge while the latch enable is high separates "latch enable has priority" from "edge capture".
- A steady high clock after the latch closes separates holding from re-capturing.
- A gated edge, followed by enabling while the clock stays high, separates edge detection from level detection.
- Data with alternating bit patterns and single set bits exposes stuck or swapped bits.

Separate directed tests then cover:
- a capture on the B-to-A path while A-to-B is transparent, which shows the two paths are independent;
- both drive flags high at the same time;
- releasing an output enable while the stored data stays in place;
- a reset in mid-run, which shows the stored values are cleared.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
// Package: shared definitions for the two-way registered transceiver.
// Assumes: controls are already synchronous to the system clock.
package xcvr_pkg;
    // Default width of one port
    localparam int unsigned XCVR_W = 18;
    // Number of one-way paths in the block
    localparam int unsigned XCVR_PATHS = 2;

    // Control bundle of one path, sampled on the system clock
    typedef struct packed {
        logic oe_n;   // active-low output enable
        logic le;     // latch enable, 1 = transparent
        logic pclk;   // path clock
        logic ce_n;   // active-low clock enable
    } path_ctl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
`timescale 1ns/1ps
// Module: xcvr_edge_det
// Finds 0-to-1 changes of a slow path clock that is sampled on clk.
// Assumes: sig_in is synchronous to clk. During reset the history takes
// the live level, so no edge is reported when reset is released.
module xcvr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    // Purpose: hold the previous sampled level of the path clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= sig_in;
        else        prev_q <= sig_in;
    end

    // Purpose: flag a rising transition seen in this cycle
    always_comb begin
        rise = sig_in & ~prev_q;
    end
endmodule

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
// Module: xcvr_store
// Storage element that acts as a latch (transparent while le is high) or
// as an edge-captured register (on a qualified edge while le is low).
// Assumes: le has priority over the edge; all inputs sampled on clk.
module xcvr_store #(
    parameter int unsigned W = xcvr_pkg::XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         edge_hit,
    input  logic         ce_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic         load;
    logic [W-1:0] q_r;

    // Purpose: decide whether this cycle writes new data
    always_comb begin
        load = le | (edge_hit & ~ce_n);
    end

    // Purpose: the storage register itself, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (load) q_r <= d;
    end

    // Purpose: output always comes from storage
    always_comb begin
        q = q_r;
    end
endmodule

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
// Module: xcvr_path
// One direction of the transceiver: edge detection, storage and the
// drive flag for the destination port.
// Assumes: ctl fields are synchronous to clk.
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  path_ctl_t    ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    logic edge_hit;

    xcvr_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (ctl.pclk),
        .rise   (edge_hit)
    );

    xcvr_store #(.W(W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (ctl.le),
        .edge_hit (edge_hit),
        .ce_n     (ctl.ce_n),
        .d        (din),
        .q        (dout)
    );

    // Purpose: drive flag, forced off while reset is held
    always_comb begin
        drive = rst_n & ~ctl.oe_n;
    end
endmodule

// File: rtl/xcvr_bidir.sv
`timescale 1ns/1ps
// Module: xcvr_bidir (top)
// Two-port transceiver with independent A-to-B and B-to-A paths. Each
// port is split into in/out/drive so the caller builds the tri-state.
// Assumes: one system clock; no contention protection between paths.
module xcvr_bidir
    import xcvr_pkg::*;
#(
    parameter int unsigned W = XCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_pclk,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_pclk,
    input  logic         ba_ce_n
);
    localparam int unsigned NP = XCVR_PATHS;
    localparam int unsigned P_AB = 0;
    localparam int unsigned P_BA = 1;

    path_ctl_t    ctl  [NP];
    logic [W-1:0] src  [NP];
    logic [W-1:0] dst  [NP];
    logic         drv  [NP];

    // Purpose: gather per-direction controls and sources into arrays
    always_comb begin
        ctl[P_AB] = '{oe_n: ab_oe_n, le: ab_le, pclk: ab_pclk, ce_n: ab_ce_n};
        ctl[P_BA] = '{oe_n: ba_oe_n, le: ba_le, pclk: ba_pclk, ce_n: ba_ce_n};
        src[P_AB] = a_in;
        src[P_BA] = b_in;
    end

    for (genvar p = 0; p < NP; p++) begin : g_path
        xcvr_path #(.W(W)) u_path (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[p]),
            .din   (src[p]),
            .dout  (dst[p]),
            .drive (drv[p])
        );
    end

    // Purpose: route path results to the destination ports
    always_comb begin
        b_out = dst[P_AB];
        b_oe  = drv[P_AB];
        a_out = dst[P_BA];
        a_oe  = drv[P_BA];
    end
endmodule

// File: rtl/xcvr_bidir_chk.sv
`timescale 1ns/1ps
// Module: xcvr_bidir_chk
// Property checker for xcvr_bidir, attached with bind. Observes ports only.
module xcvr_bidir_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_pclk,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_pclk,
    input logic         ba_ce_n
);
    // R2: transparent path follows its input one cycle later
    a_r2_ab_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |=> b_out == $past(a_in));
    a_r2_ba_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |=> a_out == $past(b_in));

    // R3: closed latch with no rising clock keeps its value
    a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !$rose(ab_pclk)) |=> $stable(b_out));

    // R4: enabled rising edge captures the input
    a_r4_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_ce_n && $rose(ab_pclk)) |=> b_out == $past(a_in));
    a_r4_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_ce_n && $rose(ba_pclk)) |=> a_out == $past(b_in));

    // R5: gated edge stores nothing
    a_r5_ab_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_ce_n) |=> $stable(b_out));

    // R6: released output enable never drives
    a_r6_ab_float: assert property (@(posedge clk) ab_oe_n |-> !b_oe);
    a_r6_ba_float: assert property (@(posedge clk) ba_oe_n |-> !a_oe);

    // R9: no path drives while reset is held
    a_r9_reset_quiet: assert property (@(posedge clk) !rst_n |-> (!a_oe && !b_oe));
endmodule

bind xcvr_bidir xcvr_bidir_chk #(.W(W)) u_chk (.*);

// File: tb/tb_xcvr_bidir.sv
`timescale 1ns/1ps
module tb_xcvr_bidir;
    localparam int W = 18;
    localparam int NV = 12;
    // vector: {le, pclk, ce_n, a_in[17:0], expected b_out[17:0]}
    localparam logic [38:0] VEC [NV] = '{
        {3'b101, 18'h12345, 18'h12345},  // R2 transparent
        {3'b111, 18'h00FFF, 18'h00FFF},  // R2 le has priority over edge
        {3'b010, 18'h3FFFF, 18'h00FFF},  // R7 latch closes, clock high
        {3'b000, 18'h2AAAA, 18'h00FFF},  // R3 hold
        {3'b010, 18'h15555, 18'h15555},  // R4 capture
        {3'b010, 18'h0F0F0, 18'h15555},  // R3 steady high
        {3'b001, 18'h0F0F0, 18'h15555},  // R3 clock falls
        {3'b011, 18'h0F0F0, 18'h15555},  // R5 gated edge
        {3'b010, 18'h0F0F0, 18'h15555},  // R5 late enable, no edge
        {3'b000, 18'h00001, 18'h15555},  // R3 hold
        {3'b010, 18'h00001, 18'h00001},  // R4 capture single bit
        {3'b110, 18'h3FFFF, 18'h3FFFF}   // R2 transparent again
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic a_oe, b_oe;
    logic ab_oe_n, ab_le, ab_pclk, ab_ce_n;
    logic ba_oe_n, ba_le, ba_pclk, ba_ce_n;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xcvr_bidir #(.W(W)) dut (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_in = '0; b_in = '0;
        ab_oe_n = 1'b0; ab_le = 1'b0; ab_pclk = 1'b0; ab_ce_n = 1'b1;
        ba_oe_n = 1'b0; ba_le = 1'b0; ba_pclk = 1'b0; ba_ce_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 b_oe in reset", {17'd0, b_oe}, 18'd0);
        check("R9 a_oe in reset", {17'd0, a_oe}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 b_out after reset", b_out, 18'd0);
        check("R9 a_out after reset", a_out, 18'd0);
        check("R6 b_oe enabled", {17'd0, b_oe}, 18'd1);

        // R1..R7 table walk on the A-to-B path
        for (int i = 0; i < NV; i++) begin
            {ab_le, ab_pclk, ab_ce_n, a_in} = VEC[i][38:18];
            @(negedge clk);
            check($sformatf("R2-R7 vector %0d", i), b_out, VEC[i][17:0]);
        end

        // R8: B-to-A capture while A-to-B stays transparent
        b_in = 18'h2468A; ba_ce_n = 1'b0; ba_pclk = 1'b1;
        @(negedge clk);
        check("R8 B-to-A capture", a_out, 18'h2468A);
        check("R8 A-to-B unaffected", b_out, 18'h3FFFF);
        check("R8 both drive", {16'd0, a_oe, b_oe}, 18'd3);

        // R6: release A-to-B enable, data kept
        ab_oe_n = 1'b1;
        #1;
        check("R6 b_oe released", {17'd0, b_oe}, 18'd0);
        check("R6 a_oe unaffected", {17'd0, a_oe}, 18'd1);
        @(negedge clk);
        check("R6 data kept when floating", b_out, 18'h3FFFF);

        // R9: mid-run reset clears both paths
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset b_out", b_out, 18'd0);
        check("R9 mid reset a_out", a_out, 18'd0);
        check("R9 mid reset a_oe", {17'd0, a_oe}, 18'd0);
        ab_le = 1'b0; ab_pclk = 1'b1; ab_ce_n = 1'b0; a_in = 18'h1ABCD;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 high clock at release no edge", b_out, 18'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule